// File: doc/BRIEF.md
# Banked Double-Buffer Memory Controller

This block owns a local data memory made of two groups of equal-sized SRAM banks and alternates the groups between two users. In every period of a job one group belongs to the compute side and the other to the transfer (DMA) side. The transfer side loads the next tile while the compute side works on the current one. When both sides have finished their share of the period, the groups exchange roles. Transfer time is therefore hidden behind computation whenever the two take a similar number of cycles.

Each side has its own request port. A port names the group it wants and a word address inside that group. The controller routes the access to that group only when the port currently owns it. Inside a group the low address bits pick a bank and the upper bits pick a row, so a run of sequential words rotates through every bank. A job of T tiles runs as T+1 periods:
- the first period is a fill period with transfer only;
- the last period is a drain period with compute only.

A full-size build holds 2 MB in 32 banks of 8-byte words, which caps one tile at half of that. The default parameters give a smaller row depth so that the project elaborates quickly.

Top module: `pingpong_bank_ctrl`

## Requirements
- R1: After reset, `busy`, `fill_phase`, `drain_phase`, `job_done`, both error flags and both read-valid outputs are 0, and `cmp_grp_sel` is 0.
- R2: A `job_start` pulse while idle with `job_tiles` ≥ 1 makes the block busy in period 0 (`tile_idx`=0, `fill_phase`=1, `cmp_grp_sel`=0) on the next cycle and clears both error flags. A start with `job_tiles`=0, or any start while busy, has no effect.
- R3: In a period where both sides are active, the swap waits until both `cmp_done` and `dma_done` have been seen. The swap takes effect on the cycle after the second arrives, whether the two arrive in either order or together. An earlier pulse is held until then. The swap toggles `cmp_grp_sel` and increments `tile_idx`.
- R4: In the fill period (index 0) only `dma_done` is needed and `cmp_done` is ignored. In the drain period (index T) only `cmp_done` is needed and `dma_done` is ignored. When the drain period completes, `busy` falls and `job_done` pulses high for exactly one cycle, after T+1 swaps in total.
- R5: Within a group, word address bits [3:0] choose one of 16 banks and the remaining bits choose the row. Words written at any addresses, including consecutive addresses and the last address, read back unchanged.
- R6: The two groups are separate storage: the same word address in group 0 and in group 1 holds independent data.
- R7: The compute port owns the group numbered `cmp_grp_sel` and the DMA port owns the other one. An access whose group input (`cmp_grp` / `dma_grp`, 0 or 1) names the group the port does not own changes no memory and returns no read-valid. It also sets that port's sticky error flag on the next cycle.
- R8: An accepted read returns its data with read-valid exactly one cycle after the request, on the requesting port only. A write never raises read-valid. Both ports may be served in the same cycle.
- R9: `cmp_done` and `dma_done` pulses while idle change neither `busy` nor `cmp_grp_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| job_start | input | 1 | Start pulse for a job |
| job_tiles | input | TILE_W | Number of tiles in the job |
| cmp_done | input | 1 | Compute side finished the current period |
| dma_done | input | 1 | Transfer side finished the current period |
| cmp_req | input | 1 | Compute port access request |
| cmp_we | input | 1 | Compute port write enable |
| cmp_grp | input | 1 | Group targeted by the compute port |
| cmp_addr | input | ADDR_W | Compute port word address in the group |
| cmp_wdata | input | DATA_W | Compute port write data |
| cmp_rdata | output | DATA_W | Compute port read data |
| cmp_rvalid | output | 1 | Compute port read data valid |
| cmp_err | output | 1 | Sticky flag: compute port touched the wrong group |
| dma_req | input | 1 | DMA port access request |
| dma_we | input | 1 | DMA port write enable |
| dma_grp | input | 1 | Group targeted by the DMA port |
| dma_addr | input | ADDR_W | DMA port word address in the group |
| dma_wdata | input | DATA_W | DMA port write data |
| dma_rdata | output | DATA_W | DMA port read data |
| dma_rvalid | output | 1 | DMA port read data valid |
| dma_err | output | 1 | Sticky flag: DMA port touched the wrong group |
| cmp_grp_sel | output | 1 | Group currently owned by the compute side |
| busy | output | 1 | A job is running |
| tile_idx | output | TILE_W | Index of the current period |
| fill_phase | output | 1 | Current period is the transfer-only fill |
| drain_phase | output | 1 | Current period is the compute-only drain |
| job_done | output | 1 | One-cycle pulse when the last period ends |

## Verification
The following properties are checked on every cycle:
- reset state;
- a read-valid is always preceded by an accepted read on that same port;
- a wrong-group access never yields data but always raises its error flag;
- fill and drain never coexist;
- the fill period cannot end without `dma_done`, and the drain period cannot end without `cmp_done`.

Only the bench scenarios can show the rest: that the first done pulse is held until the second arrives, the count of T+1 swaps with the single `job_done` pulse, and that stored data survives across the bank interleave and stays separate between the groups. The bench checks these against a software memory model and an independently tracked owner group.

// File: rtl/pp_pkg.sv
// Package: shared types for the double-buffer controller.
// Assumes: one package per build; no widths depend on it.
package pp_pkg;
    // Period classification of the job sequencer.
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_FILL   = 2'd1,
        PH_STEADY = 2'd2,
        PH_DRAIN  = 2'd3
    } phase_e;
endpackage

// File: rtl/pp_bank_sram.sv
// Module: one behavioural SRAM bank with a registered read port.
// Assumes: at most one access per cycle; contents are not reset.
module pp_bank_sram #(
    parameter int ROWS   = 64,
    parameter int DATA_W = 64,
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [ROW_W-1:0]  row,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [ROWS];

    // Write on enabled write, capture read data on enabled read.
    always_ff @(posedge clk) begin
        if (en && we) begin
            mem[row] <= wdata;
        end
        if (en && !we) begin
            rdata <= mem[row];
        end
    end
endmodule

// File: rtl/pp_bank_group.sv
// Module: a group of interleaved banks seen as one word-addressed memory.
// Low address bits pick the bank, the upper bits pick the row.
// Assumes: at most one access per cycle reaches the group.
module pp_bank_group #(
    parameter int BANKS  = 16,
    parameter int ROWS   = 64,
    parameter int DATA_W = 64,
    localparam int BANK_W = $clog2(BANKS),
    localparam int ROW_W  = $clog2(ROWS),
    localparam int ADDR_W = BANK_W + ROW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [BANK_W-1:0] bank_sel;
    logic [ROW_W-1:0]  row_sel;
    logic [BANK_W-1:0] bank_q;
    logic [DATA_W-1:0] bank_rdata [BANKS];

    // Split the word address into bank and row fields.
    always_comb begin
        bank_sel = addr[BANK_W-1:0];
        row_sel  = addr[ADDR_W-1:BANK_W];
    end

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic bank_en;
        // Enable only the bank that the low address bits pick.
        always_comb bank_en = en && (bank_sel == BANK_W'(b));

        pp_bank_sram #(.ROWS(ROWS), .DATA_W(DATA_W)) u_sram (
            .clk   (clk),
            .en    (bank_en),
            .we    (we),
            .row   (row_sel),
            .wdata (wdata),
            .rdata (bank_rdata[b])
        );
    end

    // Remember which bank a read went to, for the return mux.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else if (en && !we) begin
            bank_q <= bank_sel;
        end
    end

    // Return the data of the bank that served the last read.
    always_comb rdata = bank_rdata[bank_q];
endmodule

// File: rtl/pp_port_gate.sv
// Module: ownership check for one access port.
// Grants a request only if it targets the group the port owns;
// otherwise raises a sticky error flag that a new job clears.
// Assumes: owned_grp is stable within the request cycle.
module pp_port_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic grp,
    input  logic owned_grp,
    input  logic clear,
    output logic grant,
    output logic err
);
    logic miss;

    // Decide grant or miss for this cycle's request.
    always_comb begin
        grant = req && (grp == owned_grp);
        miss  = req && (grp != owned_grp);
    end

    // Sticky error: a miss sets it (winning over clear), a new job clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err <= 1'b0;
        end else if (miss) begin
            err <= 1'b1;
        end else if (clear) begin
            err <= 1'b0;
        end
    end
endmodule

// File: rtl/pp_swap_seq.sv
// Module: job sequencer for the double buffer.
// Walks T+1 periods (fill, T-1 steady, drain), holds whichever done
// pulse arrives first and swaps group ownership once both are in.
// Assumes: done pulses are single-cycle; job_tiles is sampled at start.
module pp_swap_seq
    import pp_pkg::*;
#(
    parameter int TILE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              job_start,
    input  logic [TILE_W-1:0] job_tiles,
    input  logic              cmp_done,
    input  logic              dma_done,
    output logic              start_ok,
    output logic              grp_sel,
    output logic              busy,
    output logic [TILE_W-1:0] tile_idx,
    output logic              fill_phase,
    output logic              drain_phase,
    output logic              job_done
);
    logic [TILE_W-1:0] tiles_q;
    logic              cmp_seen_q;
    logic              dma_seen_q;
    logic              cmp_active;
    logic              dma_active;
    logic              cmp_ok;
    logic              dma_ok;
    logic              swap;
    logic              last_period;
    phase_e            phase;

    // Classify the current period.
    always_comb begin
        last_period = (tile_idx == tiles_q);
        if (!busy) begin
            phase = PH_IDLE;
        end else if (tile_idx == '0) begin
            phase = PH_FILL;
        end else if (last_period) begin
            phase = PH_DRAIN;
        end else begin
            phase = PH_STEADY;
        end
    end

    // Work out which sides are active and whether the swap may happen.
    always_comb begin
        cmp_active  = (phase == PH_STEADY) || (phase == PH_DRAIN);
        dma_active  = (phase == PH_STEADY) || (phase == PH_FILL);
        cmp_ok      = !cmp_active || cmp_seen_q || cmp_done;
        dma_ok      = !dma_active || dma_seen_q || dma_done;
        swap        = busy && cmp_ok && dma_ok;
        start_ok    = job_start && !busy && (job_tiles != '0);
        fill_phase  = (phase == PH_FILL);
        drain_phase = (phase == PH_DRAIN);
    end

    // Advance periods, hold early done pulses, toggle ownership.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            tile_idx   <= '0;
            tiles_q    <= '0;
            grp_sel    <= 1'b0;
            cmp_seen_q <= 1'b0;
            dma_seen_q <= 1'b0;
            job_done   <= 1'b0;
        end else begin
            job_done <= 1'b0;
            if (start_ok) begin
                busy       <= 1'b1;
                tile_idx   <= '0;
                tiles_q    <= job_tiles;
                grp_sel    <= 1'b0;
                cmp_seen_q <= 1'b0;
                dma_seen_q <= 1'b0;
            end else if (swap) begin
                grp_sel    <= !grp_sel;
                cmp_seen_q <= 1'b0;
                dma_seen_q <= 1'b0;
                if (last_period) begin
                    busy     <= 1'b0;
                    job_done <= 1'b1;
                end else begin
                    tile_idx <= tile_idx + 1'b1;
                end
            end else begin
                cmp_seen_q <= cmp_seen_q || (cmp_done && cmp_active);
                dma_seen_q <= dma_seen_q || (dma_done && dma_active);
            end
        end
    end
endmodule

// File: rtl/pingpong_bank_ctrl.sv
// Module: top of the banked double-buffer controller.
// Two groups of interleaved banks; the compute port owns the group named
// by cmp_grp_sel, the DMA port owns the other; ownership swaps per period.
// Assumes: requests are single-cycle; read data returns one cycle later.
module pingpong_bank_ctrl #(
    parameter int BANKS_PER_GRP = 16,
    parameter int ROWS          = 64,
    parameter int DATA_W        = 64,
    parameter int TILE_W        = 8,
    localparam int ADDR_W = $clog2(BANKS_PER_GRP) + $clog2(ROWS),
    localparam int GROUPS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              job_start,
    input  logic [TILE_W-1:0] job_tiles,
    input  logic              cmp_done,
    input  logic              dma_done,
    input  logic              cmp_req,
    input  logic              cmp_we,
    input  logic              cmp_grp,
    input  logic [ADDR_W-1:0] cmp_addr,
    input  logic [DATA_W-1:0] cmp_wdata,
    output logic [DATA_W-1:0] cmp_rdata,
    output logic              cmp_rvalid,
    output logic              cmp_err,
    input  logic              dma_req,
    input  logic              dma_we,
    input  logic              dma_grp,
    input  logic [ADDR_W-1:0] dma_addr,
    input  logic [DATA_W-1:0] dma_wdata,
    output logic [DATA_W-1:0] dma_rdata,
    output logic              dma_rvalid,
    output logic              dma_err,
    output logic              cmp_grp_sel,
    output logic              busy,
    output logic [TILE_W-1:0] tile_idx,
    output logic              fill_phase,
    output logic              drain_phase,
    output logic              job_done
);
    logic              start_ok;
    logic              cmp_grant;
    logic              dma_grant;
    logic              cmp_rgrp_q;
    logic              dma_rgrp_q;
    logic [DATA_W-1:0] grp_rdata [GROUPS];

    pp_swap_seq #(.TILE_W(TILE_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .job_start   (job_start),
        .job_tiles   (job_tiles),
        .cmp_done    (cmp_done),
        .dma_done    (dma_done),
        .start_ok    (start_ok),
        .grp_sel     (cmp_grp_sel),
        .busy        (busy),
        .tile_idx    (tile_idx),
        .fill_phase  (fill_phase),
        .drain_phase (drain_phase),
        .job_done    (job_done)
    );

    pp_port_gate u_cmp_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (cmp_req),
        .grp       (cmp_grp),
        .owned_grp (cmp_grp_sel),
        .clear     (start_ok),
        .grant     (cmp_grant),
        .err       (cmp_err)
    );

    pp_port_gate u_dma_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (dma_req),
        .grp       (dma_grp),
        .owned_grp (!cmp_grp_sel),
        .clear     (start_ok),
        .grant     (dma_grant),
        .err       (dma_err)
    );

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        localparam logic GID = 1'(g);
        logic              c_hit;
        logic              d_hit;
        logic              en;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;

        // Steer the granted port (at most one) onto this group.
        always_comb begin
            c_hit = cmp_grant && (cmp_grp == GID);
            d_hit = dma_grant && (dma_grp == GID);
            en    = c_hit || d_hit;
            we    = c_hit ? cmp_we    : dma_we;
            addr  = c_hit ? cmp_addr  : dma_addr;
            wdata = c_hit ? cmp_wdata : dma_wdata;
        end

        pp_bank_group #(
            .BANKS  (BANKS_PER_GRP),
            .ROWS   (ROWS),
            .DATA_W (DATA_W)
        ) u_group (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (en),
            .we    (we),
            .addr  (addr),
            .wdata (wdata),
            .rdata (grp_rdata[g])
        );
    end

    // Track pending read returns and the group each one came from.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_rvalid <= 1'b0;
            dma_rvalid <= 1'b0;
            cmp_rgrp_q <= 1'b0;
            dma_rgrp_q <= 1'b0;
        end else begin
            cmp_rvalid <= cmp_grant && !cmp_we;
            dma_rvalid <= dma_grant && !dma_we;
            cmp_rgrp_q <= cmp_grp;
            dma_rgrp_q <= dma_grp;
        end
    end

    // Return each port's data from the group that served it.
    always_comb begin
        cmp_rdata = grp_rdata[cmp_rgrp_q];
        dma_rdata = grp_rdata[dma_rgrp_q];
    end
endmodule

// File: rtl/pingpong_bank_ctrl_chk.sv
// Module: assertion checker bound to pingpong_bank_ctrl.
// Assumes: it sees only the top-level ports.
module pingpong_bank_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic cmp_req,
    input logic cmp_we,
    input logic cmp_grp,
    input logic dma_req,
    input logic dma_we,
    input logic dma_grp,
    input logic cmp_done,
    input logic dma_done,
    input logic cmp_rvalid,
    input logic dma_rvalid,
    input logic cmp_err,
    input logic dma_err,
    input logic cmp_grp_sel,
    input logic busy,
    input logic fill_phase,
    input logic drain_phase,
    input logic job_done
);
    // R1: reset leaves the block idle with no flags set.
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (!busy && !cmp_grp_sel && !cmp_err && !dma_err
                    && !cmp_rvalid && !dma_rvalid && !job_done));

    // R4: fill and drain are exclusive and only occur while busy.
    a_r4_phase_excl: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_phase || drain_phase) |-> (busy && !(fill_phase && drain_phase)));

    // R4: the fill period cannot end without dma_done.
    a_r4_fill_waits_dma: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_phase && !dma_done) |=> fill_phase);

    // R4: the drain period cannot end without cmp_done.
    a_r4_drain_waits_cmp: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_phase && !cmp_done) |=> drain_phase);

    // R7: a wrong-group compute read returns nothing and raises the flag.
    a_r7_cmp_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_req && (cmp_grp != cmp_grp_sel)) |=> (cmp_err && !cmp_rvalid));

    // R7: a wrong-group DMA access returns nothing and raises the flag.
    a_r7_dma_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && (dma_grp == cmp_grp_sel)) |=> (dma_err && !dma_rvalid));

    // R8: compute read-valid only follows an accepted compute read.
    a_r8_cmp_rvalid_src: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_rvalid |-> $past(cmp_req && !cmp_we && (cmp_grp == cmp_grp_sel)));

    // R8: DMA read-valid only follows an accepted DMA read.
    a_r8_dma_rvalid_src: assert property (@(posedge clk) disable iff (!rst_n)
        dma_rvalid |-> $past(dma_req && !dma_we && (dma_grp != cmp_grp_sel)));
endmodule

bind pingpong_bank_ctrl pingpong_bank_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmp_req     (cmp_req),
    .cmp_we      (cmp_we),
    .cmp_grp     (cmp_grp),
    .dma_req     (dma_req),
    .dma_we      (dma_we),
    .dma_grp     (dma_grp),
    .cmp_done    (cmp_done),
    .dma_done    (dma_done),
    .cmp_rvalid  (cmp_rvalid),
    .dma_rvalid  (dma_rvalid),
    .cmp_err     (cmp_err),
    .dma_err     (dma_err),
    .cmp_grp_sel (cmp_grp_sel),
    .busy        (busy),
    .fill_phase  (fill_phase),
    .drain_phase (drain_phase),
    .job_done    (job_done)
);

// File: tb/pingpong_bank_ctrl_bench.sv
// Bench: directed sequencing scenarios plus seeded random accesses,
// checked against a software memory model and a tracked owner group.
module pingpong_bank_ctrl_bench;
    localparam int AW = 10;
    localparam int DW = 64;
    localparam int TW = 8;
    localparam int WORDS = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          job_start = 1'b0;
    logic [TW-1:0] job_tiles = '0;
    logic          cmp_done = 1'b0;
    logic          dma_done = 1'b0;
    logic          cmp_req = 1'b0, cmp_we = 1'b0, cmp_grp = 1'b0;
    logic [AW-1:0] cmp_addr = '0;
    logic [DW-1:0] cmp_wdata = '0;
    logic [DW-1:0] cmp_rdata;
    logic          cmp_rvalid, cmp_err;
    logic          dma_req = 1'b0, dma_we = 1'b0, dma_grp = 1'b0;
    logic [AW-1:0] dma_addr = '0;
    logic [DW-1:0] dma_wdata = '0;
    logic [DW-1:0] dma_rdata;
    logic          dma_rvalid, dma_err;
    logic          cmp_grp_sel, busy, fill_phase, drain_phase, job_done;
    logic [TW-1:0] tile_idx;

    pingpong_bank_ctrl u_pingpong_bank_ctrl (
        .clk(clk), .rst_n(rst_n), .job_start(job_start), .job_tiles(job_tiles),
        .cmp_done(cmp_done), .dma_done(dma_done),
        .cmp_req(cmp_req), .cmp_we(cmp_we), .cmp_grp(cmp_grp),
        .cmp_addr(cmp_addr), .cmp_wdata(cmp_wdata), .cmp_rdata(cmp_rdata),
        .cmp_rvalid(cmp_rvalid), .cmp_err(cmp_err),
        .dma_req(dma_req), .dma_we(dma_we), .dma_grp(dma_grp),
        .dma_addr(dma_addr), .dma_wdata(dma_wdata), .dma_rdata(dma_rdata),
        .dma_rvalid(dma_rvalid), .dma_err(dma_err),
        .cmp_grp_sel(cmp_grp_sel), .busy(busy), .tile_idx(tile_idx),
        .fill_phase(fill_phase), .drain_phase(drain_phase), .job_done(job_done)
    );

    always #2 clk = !clk;   // 250 MHz

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;
    bit finished = 1'b0;

    logic [DW-1:0] model [2][WORDS];
    bit            model_ok [2][WORDS];
    logic          exp_sel = 1'b0;
    logic          exp_cerr = 1'b0;
    logic          exp_derr = 1'b0;

    // Record one comparison; print a FAIL line on mismatch.
    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    function automatic bit owns(input bit is_dma, input logic grp, input logic sel);
        return is_dma ? (grp != sel) : (grp == sel);
    endfunction

    // Drive one cycle of accesses on both ports and check the returns.
    task automatic access(input bit c_en, input logic c_g, input logic [AW-1:0] c_a,
                          input bit c_w, input logic [DW-1:0] c_d,
                          input bit d_en, input logic d_g, input logic [AW-1:0] d_a,
                          input bit d_w, input logic [DW-1:0] d_d);
        bit c_ok, d_ok;
        logic [DW-1:0] c_exp, d_exp;
        c_ok = c_en && owns(1'b0, c_g, exp_sel);
        d_ok = d_en && owns(1'b1, d_g, exp_sel);
        c_exp = model[c_g][c_a];
        d_exp = model[d_g][d_a];
        cmp_req = c_en; cmp_we = c_w; cmp_grp = c_g; cmp_addr = c_a; cmp_wdata = c_d;
        dma_req = d_en; dma_we = d_w; dma_grp = d_g; dma_addr = d_a; dma_wdata = d_d;
        tick();
        cmp_req = 1'b0;
        dma_req = 1'b0;
        if (c_en && !c_ok) exp_cerr = 1'b1;
        if (d_en && !d_ok) exp_derr = 1'b1;
        // R8 read-valid timing, R7 blocking
        chk(cmp_rvalid == (c_ok && !c_w), "R8/R7 cmp_rvalid", DW'(cmp_rvalid), DW'(c_ok && !c_w));
        chk(dma_rvalid == (d_ok && !d_w), "R8/R7 dma_rvalid", DW'(dma_rvalid), DW'(d_ok && !d_w));
        if (c_ok && !c_w && model_ok[c_g][c_a])
            chk(cmp_rdata == c_exp, "R5/R6 cmp_rdata", cmp_rdata, c_exp);
        if (d_ok && !d_w && model_ok[d_g][d_a])
            chk(dma_rdata == d_exp, "R5/R6 dma_rdata", dma_rdata, d_exp);
        chk(cmp_err == exp_cerr, "R7 cmp_err", DW'(cmp_err), DW'(exp_cerr));
        chk(dma_err == exp_derr, "R7 dma_err", DW'(dma_err), DW'(exp_derr));
        if (c_ok && c_w) begin model[c_g][c_a] = c_d; model_ok[c_g][c_a] = 1'b1; end
        if (d_ok && d_w) begin model[d_g][d_a] = d_d; model_ok[d_g][d_a] = 1'b1; end
    endtask

    task automatic pulse(input bit cd, input bit dd);
        cmp_done = cd;
        dma_done = dd;
        tick();
        cmp_done = 1'b0;
        dma_done = 1'b0;
    endtask

    task automatic start(input logic [TW-1:0] t);
        job_start = 1'b1;
        job_tiles = t;
        tick();
        job_start = 1'b0;
    endtask

    task automatic state_chk(input string tag, input bit e_busy, input logic [TW-1:0] e_idx,
                             input bit e_fill, input bit e_drain);
        chk(busy == e_busy, {tag, " busy"}, DW'(busy), DW'(e_busy));
        chk(cmp_grp_sel == exp_sel, {tag, " cmp_grp_sel"}, DW'(cmp_grp_sel), DW'(exp_sel));
        if (e_busy) chk(tile_idx == e_idx, {tag, " tile_idx"}, DW'(tile_idx), DW'(e_idx));
        chk(fill_phase == e_fill, {tag, " fill_phase"}, DW'(fill_phase), DW'(e_fill));
        chk(drain_phase == e_drain, {tag, " drain_phase"}, DW'(drain_phase), DW'(e_drain));
    endtask

    task automatic random_ops(input int n);
        for (int i = 0; i < n; i++) begin
            logic [31:0] r;
            r = $urandom;
            access(r[0], r[1] ? ~exp_sel : exp_sel ^ (r[2] & r[3] & r[4]),
                   AW'($urandom), r[5], {$urandom, $urandom},
                   r[6], r[7] ? exp_sel ^ (r[8] & r[9] & r[10]) : ~exp_sel,
                   AW'($urandom), r[11], {$urandom, $urandom});
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        while (!finished) begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000 && !finished) begin
                n_fail++;
                n_checks++;
                $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
                $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int g = 0; g < 2; g++)
            for (int a = 0; a < WORDS; a++) begin
                model[g][a] = '0;
                model_ok[g][a] = 1'b0;
            end
        tick(); tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        state_chk("R1", 1'b0, '0, 1'b0, 1'b0);
        chk(!cmp_err && !dma_err, "R1 err flags", DW'({cmp_err, dma_err}), '0);
        chk(!cmp_rvalid && !dma_rvalid && !job_done, "R1 rvalid/job_done",
            DW'({cmp_rvalid, dma_rvalid, job_done}), '0);

        // R9 stray done pulses while idle
        pulse(1'b1, 1'b1);
        state_chk("R9 idle done", 1'b0, '0, 1'b0, 1'b0);
        // R2 zero-tile start ignored
        start('0);
        state_chk("R2 zero tiles", 1'b0, '0, 1'b0, 1'b0);

        // R5 interleave: consecutive words, row boundary and last word,
        // R6 same addresses in both groups hold separate data
        for (int a = 0; a < 18; a++)
            access(1'b1, 1'b0, AW'(a), 1'b1, 64'hC0DE_0000_0000_0000 | 64'(a),
                   1'b1, 1'b1, AW'(a), 1'b1, 64'hD0A0_0000_0000_0000 | 64'(a));
        access(1'b1, 1'b0, AW'(WORDS-1), 1'b1, 64'hFFFF_0000_1111_2222,
               1'b1, 1'b1, AW'(WORDS-1), 1'b1, 64'h3333_4444_5555_6666);
        for (int a = 0; a < 18; a++)
            access(1'b1, 1'b0, AW'(a), 1'b0, '0, 1'b1, 1'b1, AW'(a), 1'b0, '0);
        access(1'b1, 1'b0, AW'(WORDS-1), 1'b0, '0, 1'b1, 1'b1, AW'(WORDS-1), 1'b0, '0);

        // R7 directed wrong-group accesses on each port
        access(1'b1, 1'b1, AW'(5), 1'b1, 64'hBAD, 1'b0, 1'b0, '0, 1'b0, '0);
        access(1'b0, 1'b0, '0, 1'b0, '0, 1'b1, 1'b0, AW'(5), 1'b1, 64'hBAD);
        access(1'b1, 1'b0, AW'(5), 1'b0, '0, 1'b1, 1'b1, AW'(5), 1'b0, '0);

        random_ops(300);

        // R2 start a three-tile job; errors clear
        start(TW'(3));
        exp_cerr = 1'b0; exp_derr = 1'b0;
        state_chk("R2 start", 1'b1, '0, 1'b1, 1'b0);
        chk(!cmp_err && !dma_err, "R2 err cleared", DW'({cmp_err, dma_err}), '0);
        // R4 fill: compute done ignored, dma done alone swaps
        pulse(1'b1, 1'b0);
        state_chk("R4 fill cmp ignored", 1'b1, '0, 1'b1, 1'b0);
        pulse(1'b0, 1'b1);
        exp_sel = ~exp_sel;
        state_chk("R4 fill swap", 1'b1, TW'(1), 1'b0, 1'b0);
        // R3 compute first, held, then dma
        pulse(1'b1, 1'b0);
        tick(); tick();
        state_chk("R3 cmp held", 1'b1, TW'(1), 1'b0, 1'b0);
        pulse(1'b0, 1'b1);
        exp_sel = ~exp_sel;
        state_chk("R3 swap after dma", 1'b1, TW'(2), 1'b0, 1'b0);
        // R3 dma first, held, then compute
        pulse(1'b0, 1'b1);
        tick();
        state_chk("R3 dma held", 1'b1, TW'(2), 1'b0, 1'b0);
        pulse(1'b1, 1'b0);
        exp_sel = ~exp_sel;
        state_chk("R3 swap after cmp", 1'b1, TW'(3), 1'b0, 1'b1);

        random_ops(300);

        // R4 drain: dma done ignored, compute done ends the job
        pulse(1'b0, 1'b1);
        state_chk("R4 drain dma ignored", 1'b1, TW'(3), 1'b0, 1'b1);
        chk(!job_done, "R4 no early job_done", DW'(job_done), '0);
        pulse(1'b1, 1'b0);
        exp_sel = ~exp_sel;
        state_chk("R4 job end", 1'b0, '0, 1'b0, 1'b0);
        chk(job_done, "R4 job_done pulse", DW'(job_done), 64'd1);
        tick();
        chk(!job_done, "R4 job_done one cycle", DW'(job_done), '0);

        // R3 simultaneous done pulses; R2 start while busy ignored
        start(TW'(2));
        exp_cerr = 1'b0; exp_derr = 1'b0;
        state_chk("R2 second job", 1'b1, '0, 1'b1, 1'b0);
        pulse(1'b0, 1'b1);
        exp_sel = ~exp_sel;
        start(TW'(5));
        state_chk("R2 start while busy", 1'b1, TW'(1), 1'b0, 1'b0);
        pulse(1'b1, 1'b1);
        exp_sel = ~exp_sel;
        state_chk("R3 simultaneous", 1'b1, TW'(2), 1'b0, 1'b1);
        random_ops(200);
        pulse(1'b1, 1'b1);
        exp_sel = ~exp_sel;
        state_chk("R4 second job end", 1'b0, '0, 1'b0, 1'b0);
        chk(job_done, "R4 second job_done", DW'(job_done), 64'd1);

        random_ops(200);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule